// File: doc/BRIEF.md
# Cartridge Bank Select Controller

This block sits on the CPU write path into a cartridge address space and holds the bank-selection state for a banked program ROM and an optional banked external RAM. Each strobed write is classified by the top nibble of its address into one of a few register windows. It then updates one piece of selection state: the RAM enable flag, the low byte of the ROM bank, the ninth ROM bank bit, or the RAM bank number. It can also pass through as a write into the external RAM array.

The ROM bank number is 9 bits wide and is assembled from two separately written registers, so that more than 256 banks can be reached. The bank outputs are registered and change on the clock edge that samples the write strobe. The external RAM write enable is combinational from the current write and the current enable state. The surrounding memory system uses it directly, together with a 13-bit offset into the selected RAM bank. A parameter states whether external RAM is fitted at all.

Top module: `mbc_bank_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no write, rom_bank is 9'h001, ram_bank is 2'd0 and ram_on is 0.
- R2: With RAM fitted, a strobed write to 0x0000-0x1FFF sets ram_on at the next clock edge when wr_data[3:0] is 4'hA and clears it for any other low nibble; wr_data[7:4] has no effect.
- R3: With RAM not fitted (HAS_XRAM=0), ram_on stays 0 and xram_we stays 0 for every write.
- R4: A strobed write to 0x2000-0x2FFF loads wr_data[7:0] into rom_bank[7:0] at the next clock edge and leaves rom_bank[8] unchanged.
- R5: A strobed write to 0x3000-0x3FFF loads wr_data[0] into rom_bank[8] at the next clock edge; rom_bank[7:0] and wr_data[7:1] have no effect on the result.
- R6: A strobed write to 0x4000-0x5FFF loads wr_data[1:0] into ram_bank at the next clock edge.
- R7: xram_we is high in the same cycle exactly when wr_en is high, wr_addr lies in 0xA000-0xBFFF, RAM is fitted and ram_on is 1; xram_addr equals wr_addr minus 0xA000.
- R8: Writes to 0x6000-0x9FFF or 0xC000-0xFFFF, writes to 0xA000-0xBFFF, and cycles without wr_en leave rom_bank, ram_bank and ram_on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| rom_bank | output | 9 | Selected ROM bank number |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_on | output | 1 | External RAM access enabled |
| xram_we | output | 1 | Gated write enable to the external RAM array |
| xram_addr | output | 13 | Byte offset within the selected RAM bank |

## Verification
Every cycle, the assertions check the following. Each register window loads exactly its own field one edge after a strobed write. The RAM enable follows the 4'hA nibble. State holds across writes that reach no register. The external RAM enable never rises without the enable flag and a RAM-window address. Only the bench's scenarios show several things. One is the composition of the 9-bit bank from writes in either order. Another is that upper data bits are ignored. The offset value on a RAM write is also shown only there. The same stimulus is applied to a copy built with no RAM, and the bench checks that this copy never enables or writes RAM.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    parameter int ADDR_W     = 16;
    parameter int DATA_W     = 8;
    parameter int ROM_BANK_W = 9;
    parameter int RAM_BANK_W = 2;
    parameter int XOFS_W     = 13;

    localparam logic [ROM_BANK_W-1:0] ROM_BANK_RST = ROM_BANK_W'(1);
    localparam logic [3:0]            RAM_KEY      = 4'hA;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_RAMEN,
        WIN_ROMLO,
        WIN_ROMHI,
        WIN_RAMSEL,
        WIN_XRAM
    } win_e;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_on;
    } bank_state_t;

endpackage

// File: rtl/mbc_addr_decode.sv
module mbc_addr_decode
    import mbc_pkg::*;
(
    input  logic [ADDR_W-1:0] wr_addr,
    output win_e              win
);

    localparam int NIB_LO = ADDR_W - 4;

    always_comb begin
        unique case (wr_addr[ADDR_W-1:NIB_LO])
            4'h0, 4'h1: win = WIN_RAMEN;
            4'h2:       win = WIN_ROMLO;
            4'h3:       win = WIN_ROMHI;
            4'h4, 4'h5: win = WIN_RAMSEL;
            4'hA, 4'hB: win = WIN_XRAM;
            default:    win = WIN_NONE;
        endcase
    end

endmodule

// File: rtl/mbc_bank_regs.sv
module mbc_bank_regs
    import mbc_pkg::*;
#(
    parameter bit HAS_XRAM = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  win_e              win,
    input  logic [DATA_W-1:0] wr_data,
    output bank_state_t       st_q
);

    localparam int LOW_W = ROM_BANK_W - 1;

    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (win)
                WIN_RAMEN: begin
                    if (HAS_XRAM) begin
                        st_d.ram_on = (wr_data[3:0] == RAM_KEY);
                    end
                end
                WIN_ROMLO:  st_d.rom_bank[LOW_W-1:0] = wr_data[LOW_W-1:0];
                WIN_ROMHI:  st_d.rom_bank[LOW_W]     = wr_data[0];
                WIN_RAMSEL: st_d.ram_bank            = wr_data[RAM_BANK_W-1:0];
                default:    st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rom_bank <= ROM_BANK_RST;
            st_q.ram_bank <= '0;
            st_q.ram_on   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mbc_xram_gate.sv
module mbc_xram_gate
    import mbc_pkg::*;
#(
    parameter bit HAS_XRAM = 1'b1
) (
    input  logic              wr_en,
    input  win_e              win,
    input  logic              ram_on,
    input  logic [XOFS_W-1:0] addr_lo,
    output logic              xram_we,
    output logic [XOFS_W-1:0] xram_addr
);

    generate
        if (HAS_XRAM) begin : g_fitted
            always_comb xram_we = wr_en && (win == WIN_XRAM) && ram_on;
        end else begin : g_absent
            always_comb xram_we = 1'b0;
        end
    endgenerate

    // window base is aligned to 2**XOFS_W, so the offset is the low bits
    always_comb xram_addr = addr_lo;

endmodule

// File: rtl/mbc_bank_ctrl.sv
module mbc_bank_ctrl
    import mbc_pkg::*;
#(
    parameter bit HAS_XRAM = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_on,
    output logic                  xram_we,
    output logic [XOFS_W-1:0]     xram_addr
);

    win_e        win;
    bank_state_t st_q;

    mbc_addr_decode u_dec (
        .wr_addr (wr_addr),
        .win     (win)
    );

    mbc_bank_regs #(.HAS_XRAM(HAS_XRAM)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .win     (win),
        .wr_data (wr_data),
        .st_q    (st_q)
    );

    mbc_xram_gate #(.HAS_XRAM(HAS_XRAM)) u_gate (
        .wr_en     (wr_en),
        .win       (win),
        .ram_on    (st_q.ram_on),
        .addr_lo   (wr_addr[XOFS_W-1:0]),
        .xram_we   (xram_we),
        .xram_addr (xram_addr)
    );

    assign rom_bank = st_q.rom_bank;
    assign ram_bank = st_q.ram_bank;
    assign ram_on   = st_q.ram_on;

endmodule

// File: rtl/mbc_bank_ctrl_chk.sv
module mbc_bank_ctrl_chk
    import mbc_pkg::*;
#(
    parameter bit HAS_XRAM = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [DATA_W-1:0]     wr_data,
    input logic [ROM_BANK_W-1:0] rom_bank,
    input logic [RAM_BANK_W-1:0] ram_bank,
    input logic                  ram_on,
    input logic                  xram_we
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rom_bank == ROM_BANK_RST && ram_bank == '0 && !ram_on));

    assert_ram_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_XRAM && wr_en && wr_addr[15:13] == 3'b000)
        |=> (ram_on == ($past(wr_data[3:0]) == RAM_KEY)));

    assert_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_XRAM |-> (!ram_on && !xram_we));

    assert_rom_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h2)
        |=> (rom_bank[7:0] == $past(wr_data) && rom_bank[8] == $past(rom_bank[8])));

    assert_rom_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h3)
        |=> (rom_bank[8] == $past(wr_data[0]) && rom_bank[7:0] == $past(rom_bank[7:0])));

    assert_ram_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:13] == 3'b010) |=> (ram_bank == $past(wr_data[1:0])));

    assert_xram_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xram_we |-> (wr_en && ram_on && wr_addr[15:13] == 3'b101));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr < 16'h6000)
        |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_on)));

endmodule

bind mbc_bank_ctrl mbc_bank_ctrl_chk #(.HAS_XRAM(HAS_XRAM)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rom_bank (rom_bank),
    .ram_bank (ram_bank),
    .ram_on   (ram_on),
    .xram_we  (xram_we)
);

// File: tb/mbc_bank_ctrl_test.sv
module mbc_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [8:0]  rom_bank, nr_rom_bank;
    logic [1:0]  ram_bank, nr_ram_bank;
    logic        ram_on, nr_ram_on;
    logic        xram_we, nr_xram_we;
    logic [12:0] xram_addr, nr_xram_addr;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mbc_bank_ctrl #(.HAS_XRAM(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_on(ram_on),
        .xram_we(xram_we), .xram_addr(xram_addr)
    );

    mbc_bank_ctrl #(.HAS_XRAM(1'b0)) uut_nr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rom_bank(nr_rom_bank), .ram_bank(nr_ram_bank), .ram_on(nr_ram_on),
        .xram_we(nr_xram_we), .xram_addr(nr_xram_addr)
    );

    // {addr, data, expected rom_bank, expected ram_bank, expected ram_on}
    localparam int NV = 15;
    localparam logic [35:0] VEC [NV] = '{
        {16'h0000, 8'h0A, 9'h001, 2'd0, 1'b1},  // R2 enable
        {16'h2000, 8'h5C, 9'h05C, 2'd0, 1'b1},  // R4
        {16'h3000, 8'hFF, 9'h15C, 2'd0, 1'b1},  // R5 only bit 0
        {16'h2FFF, 8'h00, 9'h100, 2'd0, 1'b1},  // R4 keeps bit 8
        {16'h3FFF, 8'hFE, 9'h000, 2'd0, 1'b1},  // R5 clears bit 8
        {16'h4000, 8'h07, 9'h000, 2'd3, 1'b1},  // R6
        {16'h5FFF, 8'h02, 9'h000, 2'd2, 1'b1},  // R6
        {16'h1FFF, 8'hFA, 9'h000, 2'd2, 1'b1},  // R2 upper nibble ignored
        {16'h1234, 8'h0B, 9'h000, 2'd2, 1'b0},  // R2 disable
        {16'h6000, 8'hFF, 9'h000, 2'd2, 1'b0},  // R8
        {16'h9FFF, 8'h01, 9'h000, 2'd2, 1'b0},  // R8
        {16'hC000, 8'h0A, 9'h000, 2'd2, 1'b0},  // R8
        {16'hA000, 8'h55, 9'h000, 2'd2, 1'b0},  // R8 RAM window
        {16'h2000, 8'h81, 9'h081, 2'd2, 1'b0},  // R4
        {16'hFFFF, 8'h03, 9'h081, 2'd2, 1'b0}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [8:0] r, input logic [1:0] b, input logic o);
        check(req, {20'd0, rom_bank, ram_bank, ram_on}, {20'd0, r, b, o});
    endtask

    // drive at negedge, let the posedge register it, sample at next negedge
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #40000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_state("R1 in reset", 9'h001, 2'd0, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_state("R1 after release", 9'h001, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i][35:20], VEC[i][19:12]);
            check_state($sformatf("vector %0d R2/R4/R5/R6/R8", i),
                        VEC[i][11:3], VEC[i][2:1], VEC[i][0]);
            check("R3 no-RAM copy ram_on", {31'd0, nr_ram_on}, 32'd0);
        end

        // R8: strobe low, register address present
        @(negedge clk);
        wr_addr = 16'h2000; wr_data = 8'h33;
        @(negedge clk);
        check_state("R8 no strobe", 9'h081, 2'd2, 1'b0);

        // R7: RAM disabled blocks the write
        wr_en = 1'b1; wr_addr = 16'hA123; wr_data = 8'h99;
        #1;
        check("R7 disabled we", {31'd0, xram_we}, 32'd0);
        @(negedge clk);
        wr_en = 1'b0;
        do_write(16'h0000, 8'h3A);
        check("R2 re-enable", {31'd0, ram_on}, 32'd1);

        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'hBFFF; wr_data = 8'h42;
        #1;
        check("R7 enabled we", {31'd0, xram_we}, 32'd1);
        check("R7 offset top", {19'd0, xram_addr}, 32'h1FFF);
        check("R3 no-RAM we", {31'd0, nr_xram_we}, 32'd0);
        wr_addr = 16'hA000;
        #1;
        check("R7 offset base", {19'd0, xram_addr}, 32'h0000);
        check("R7 we base", {31'd0, xram_we}, 32'd1);
        wr_addr = 16'hC000;
        #1;
        check("R7 outside window", {31'd0, xram_we}, 32'd0);
        wr_en = 1'b0;
        #1;
        check("R7 no strobe", {31'd0, xram_we}, 32'd0);
        @(negedge clk);
        check_state("R8 after RAM writes", 9'h081, 2'd2, 1'b1);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check_state("R1 mid-run reset", 9'h001, 2'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule